// File: doc/BRIEF.md
# Pulse-Width Marker and Byte Decoder

This block turns the edge timing of a tape signal into bytes. It sits after a leader detector. Once the frame is armed, the block times every interval between two edges in clock cycles. Two consecutive intervals make one bit. A short combined cycle is a zero and a long one is a one, split by a fixed threshold. At about 150% of the standard rate, a zero sits near 3100 Hz and a one near 1550 Hz. Bits arrive MSB first and carry no line coding beyond their width.

Each frame starts with a short marker of 6 or 7 bits, and the `mode_i` input selects which. A wrong marker aborts the frame. After the marker come `len_i` data bytes and then one checksum byte. Each of these bytes is presented for one clock with a valid strobe. The marker is not part of the checksum. The data and checksum bytes are XORed into an accumulator that starts at zero, and the frame passes only if the result is zero. An interval that is too short, or no edge within the timeout, also aborts the frame. `tape_i` is expected to be synchronous to `clk_i` already.

Top module: `pw_byte_decoder`

## Requirements
- R1: After reset, `byte_vld_o`, `chk_o`, `done_ok_o`, `done_err_o` and `busy_o` are low.
- R2: `start_i` while idle makes `busy_o` high on the next cycle and samples `mode_i` and `len_i`. The first edge after that is the reference edge, and every later edge closes one interval measured in clock cycles.
- R3: Two consecutive intervals form one bit. The bit is 1 when their sum is at least `T_BIT` cycles and 0 otherwise. Bits are shifted in MSB first.
- R4: With `mode_i`=0 the marker is 6 bits and must read 0x3A (bits 111010).
- R5: With `mode_i`=1 the marker is 7 bits and must read 0x74 (bits 1110100).
- R6: A marker of the wrong value gives a one-cycle `done_err_o` pulse and no byte strobe.
- R7: After the marker, each completed byte is shown on `byte_o` with a one-cycle `byte_vld_o`. This happens in the cycle after the edge that ends its last bit. `len_i` data bytes come out with `chk_o` low.
- R8: The byte after the last data byte is the checksum byte, strobed with `chk_o` high. In that same cycle, `done_ok_o` pulses if the XOR of all data bytes and the checksum byte is zero. Otherwise `done_err_o` pulses.
- R9: An interval shorter than `T_MIN` cycles gives `done_err_o`.
- R10: If the interval counter reaches `T_MAX` cycles without an edge, `done_err_o` pulses, including while waiting for the reference edge.
- R11: `start_i` while busy is ignored, and the frame in progress completes unchanged.
- R12: With `len_i`=0 the only byte after the marker is the checksum byte.
- R13: Every done pulse coincides with `busy_o` low. Edges while idle produce no strobe and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Leader found; arm a frame |
| mode_i | input | 1 | Marker mode: 0 = 6-bit, 1 = 7-bit |
| len_i | input | LEN_W | Number of data bytes |
| tape_i | input | 1 | Synchronised tape level |
| byte_o | output | 8 | Completed byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| chk_o | output | 1 | Strobed byte is the checksum byte |
| busy_o | output | 1 | Frame in progress |
| done_ok_o | output | 1 | Frame passed the checksum |
| done_err_o | output | 1 | Frame aborted or checksum failed |

## Verification
The hardest case to reach from the ports is a bit whose total width lands exactly on the threshold. The bench sends a whole data byte with split intervals of 29+30 and 30+30 cycles, so each bit falls one cycle below or exactly at `T_BIT`. It also drops `start_i` into the middle of an interval during a frame, stops toggling after the marker to reach the timeout, and injects a 4-cycle interval. In every case a behavioural model decides the expected strobes cycle by cycle from the driven tape level.

// File: rtl/pwdec_pkg.sv
package pwdec_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_DATA} dec_st_e;

  localparam logic [3:0] MARK_LEN_SHORT = 4'd6;
  localparam logic [3:0] MARK_LEN_LONG  = 4'd7;
  localparam logic [7:0] MARK_VAL_SHORT = 8'h3A;
  localparam logic [7:0] MARK_VAL_LONG  = 8'h74;
endpackage

// File: rtl/pwd_half_timer.sv
module pwd_half_timer #(
  parameter int unsigned T_MIN = 8,
  parameter int unsigned T_MAX = 200,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tape_i,
  input  logic             active_i,
  input  logic             restart_i,
  output logic             half_vld_o,
  output logic [CNT_W-1:0] half_len_o,
  output logic             fault_o
);
  logic             tape_q, armed_q, edge_w, timeout_w;
  logic [CNT_W-1:0] cnt_q;

  assign edge_w     = tape_i ^ tape_q;
  assign timeout_w  = active_i && (cnt_q == CNT_W'(T_MAX));
  assign half_len_o = cnt_q;
  assign half_vld_o = active_i && edge_w && armed_q && !timeout_w &&
                      (cnt_q >= CNT_W'(T_MIN));
  assign fault_o    = timeout_w ||
                      (active_i && edge_w && armed_q && (cnt_q < CNT_W'(T_MIN)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tape_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      tape_q <= tape_i;
      if (restart_i) begin
        cnt_q   <= CNT_W'(1);
        armed_q <= 1'b0;
      end else if (active_i) begin
        if (edge_w) begin
          cnt_q   <= CNT_W'(1);
          armed_q <= 1'b1;
        end else if (cnt_q != CNT_W'(T_MAX)) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_q <= CNT_W'(T_MAX)));
  p_arm_on_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !restart_i && edge_w) |=> armed_q);
endmodule

// File: rtl/pwd_bit_pair.sv
module pwd_bit_pair #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned T_BIT = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             half_vld_i,
  input  logic [CNT_W-1:0] half_len_i,
  output logic             bit_vld_o,
  output logic             bit_o
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic             phase_q;
  logic [CNT_W-1:0] first_q;
  logic [SUM_W-1:0] sum_w;

  assign sum_w     = SUM_W'(first_q) + SUM_W'(half_len_i);
  assign bit_o     = (sum_w >= SUM_W'(T_BIT));
  assign bit_vld_o = half_vld_i && phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      first_q <= '0;
    end else if (!active_i) begin
      phase_q <= 1'b0;
    end else if (half_vld_i) begin
      phase_q <= !phase_q;
      if (!phase_q) first_q <= half_len_i;
    end
  end

  p_pair_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && half_vld_i && !phase_q) |=> phase_q);
  p_pair_close_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !phase_q);
endmodule

// File: rtl/pw_byte_decoder.sv
module pw_byte_decoder
  import pwdec_pkg::*;
#(
  parameter int unsigned T_MIN = 8,
  parameter int unsigned T_MAX = 200,
  parameter int unsigned T_BIT = 60,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tape_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             chk_o,
  output logic             busy_o,
  output logic             done_ok_o,
  output logic             done_err_o
);
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  dec_st_e          state_q;
  logic             mode_q, active_w, restart_w;
  logic [LEN_W-1:0] left_q;
  logic [3:0]       nbits_q, nbits_nx, mark_len;
  logic [7:0]       sr_q, sr_nx, acc_q, acc_nx, mark_val, byte_q;
  logic             vld_q, chk_q, ok_q, err_q;
  logic             half_vld, fault, bit_vld, bit_val;
  logic [CNT_W-1:0] half_len;

  assign active_w  = (state_q != ST_IDLE);
  assign restart_w = start_i && !active_w;

  pwd_half_timer #(.T_MIN(T_MIN), .T_MAX(T_MAX), .CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .tape_i,
    .active_i   (active_w),
    .restart_i  (restart_w),
    .half_vld_o (half_vld),
    .half_len_o (half_len),
    .fault_o    (fault)
  );

  pwd_bit_pair #(.CNT_W(CNT_W), .T_BIT(T_BIT)) u_pair (
    .clk_i, .rst_ni,
    .active_i   (active_w),
    .half_vld_i (half_vld),
    .half_len_i (half_len),
    .bit_vld_o  (bit_vld),
    .bit_o      (bit_val)
  );

  assign sr_nx    = {sr_q[6:0], bit_val};
  assign nbits_nx = nbits_q + 4'd1;
  assign acc_nx   = acc_q ^ sr_nx;
  assign mark_len = mode_q ? MARK_LEN_LONG : MARK_LEN_SHORT;
  assign mark_val = mode_q ? MARK_VAL_LONG : MARK_VAL_SHORT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      left_q  <= '0;
      nbits_q <= '0;
      sr_q    <= '0;
      acc_q   <= '0;
      byte_q  <= '0;
      vld_q   <= 1'b0;
      chk_q   <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      chk_q <= 1'b0;
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_MARK;
          mode_q  <= mode_i;
          left_q  <= len_i;
          nbits_q <= '0;
          sr_q    <= '0;
          acc_q   <= '0;
        end
        ST_MARK: begin
          if (fault) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (bit_vld) begin
            if (nbits_nx == mark_len) begin
              nbits_q <= '0;
              sr_q    <= '0;
              if (sr_nx == mark_val) state_q <= ST_DATA;
              else begin
                err_q   <= 1'b1;
                state_q <= ST_IDLE;
              end
            end else begin
              nbits_q <= nbits_nx;
              sr_q    <= sr_nx;
            end
          end
        end
        ST_DATA: begin
          if (fault) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (bit_vld) begin
            if (nbits_nx == 4'd8) begin
              byte_q  <= sr_nx;
              vld_q   <= 1'b1;
              chk_q   <= (left_q == '0);
              acc_q   <= acc_nx;
              nbits_q <= '0;
              sr_q    <= '0;
              if (left_q == '0) begin
                state_q <= ST_IDLE;
                ok_q    <= (acc_nx == 8'h00);
                err_q   <= (acc_nx != 8'h00);
              end else begin
                left_q <= left_q - LEN_W'(1);
              end
            end else begin
              nbits_q <= nbits_nx;
              sr_q    <= sr_nx;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign chk_o      = chk_q;
  assign busy_o     = active_w;
  assign done_ok_o  = ok_q;
  assign done_err_o = err_q;

  p_done_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_ok_o && done_err_o));
  p_chk_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_o |-> byte_vld_o);
  p_vld_spaced_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
  p_done_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_ok_o || done_err_o) |-> !busy_o);
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_mode_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mode_q));
endmodule

// File: tb/pw_byte_decoder_bench.sv
module pw_byte_decoder_bench;
  localparam int T_MIN = 8;
  localparam int T_MAX = 200;
  localparam int T_BIT = 60;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] len_i = '0;
  logic        tape = 1'b0;
  logic [7:0]  byte_o;
  logic        byte_vld_o, chk_o, busy_o, done_ok_o, done_err_o;

  always #2.5 clk_i = ~clk_i;

  pw_byte_decoder #(.T_MIN(T_MIN), .T_MAX(T_MAX), .T_BIT(T_BIT), .LEN_W(16)) u_pw_byte_decoder (
    .clk_i, .rst_ni, .start_i, .mode_i, .len_i, .tape_i(tape),
    .byte_o, .byte_vld_o, .chk_o, .busy_o, .done_ok_o, .done_err_o
  );

  int n_chk = 0, n_fail = 0;
  int n_vld = 0, n_ok = 0, n_err = 0;
  bit fin = 1'b0;

  task automatic check(input bit c, input string tag, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_st = 0, m_cnt = 0, m_arm = 0, m_ph = 0, m_first = 0, m_mode = 0;
  int m_left = 0, m_bits = 0, m_sr = 0, m_acc = 0;
  logic m_lvl = 1'b0;
  logic e_vld = 0, e_chk = 0, e_ok = 0, e_err = 0;
  logic [7:0] e_byte = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_lvl = 1'b0; e_vld = 0; e_chk = 0; e_ok = 0; e_err = 0; e_byte = '0;
    end else begin
      bit edg, fail, half, b;
      e_vld = 0; e_chk = 0; e_ok = 0; e_err = 0;
      edg = (tape != m_lvl);
      m_lvl = tape;
      if (m_st == 0) begin
        if (start_i) begin
          m_st = 1; m_cnt = 1; m_arm = 0; m_ph = 0; m_mode = mode_i;
          m_left = len_i; m_bits = 0; m_sr = 0; m_acc = 0;
        end
      end else begin
        fail = 0; half = 0; b = 0;
        if (m_cnt == T_MAX) fail = 1;
        else if (edg) begin
          if (m_arm != 0) begin
            if (m_cnt < T_MIN) fail = 1; else half = 1;
          end
          m_arm = 1;
        end
        if (half) begin
          if (m_ph == 0) begin m_first = m_cnt; m_ph = 1; end
          else begin
            m_ph = 0;
            b = ((m_first + m_cnt) >= T_BIT);
            m_sr = ((m_sr << 1) | int'(b)) & 255;
            m_bits++;
            if (m_st == 1) begin
              if (m_bits == (m_mode != 0 ? 7 : 6)) begin
                if (m_sr == (m_mode != 0 ? 'h74 : 'h3A)) begin m_st = 2; m_bits = 0; m_sr = 0; end
                else begin e_err = 1; m_st = 0; end
              end
            end else if (m_bits == 8) begin
              e_vld = 1; e_byte = 8'(m_sr); e_chk = (m_left == 0);
              m_acc = m_acc ^ m_sr;
              if (m_left == 0) begin
                if (m_acc == 0) e_ok = 1; else e_err = 1;
                m_st = 0;
              end else m_left--;
              m_bits = 0; m_sr = 0;
            end
          end
        end
        m_cnt = edg ? 1 : m_cnt + 1;
        if (fail) begin e_err = 1; m_st = 0; end
      end
    end
  end

  always @(negedge clk_i) begin
    if (!fin && rst_ni) begin
      check(byte_vld_o === e_vld, "R7 byte strobe", byte_vld_o, e_vld);
      if (e_vld) check(byte_o === e_byte, "R3 byte value", byte_o, e_byte);
      check(chk_o === e_chk, "R12 checksum flag", chk_o, e_chk);
      check(done_ok_o === e_ok, "R8 done ok", done_ok_o, e_ok);
      check(done_err_o === e_err, "R6 done err", done_err_o, e_err);
      check(busy_o === (m_st != 0), "R13 busy", busy_o, int'(m_st != 0));
      if (byte_vld_o) n_vld++;
      if (done_ok_o) n_ok++;
      if (done_err_o) n_err++;
    end
  end

  task automatic half(input int n);
    repeat (n) @(negedge clk_i);
    tape = ~tape;
  endtask

  task automatic bit_t(input int a, input int b);
    half(a); half(b);
  endtask

  task automatic send_bit(input bit b);
    if (b) bit_t(40, 40); else bit_t(20, 20);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic begin_frame(input bit m, input int len, input bit good_mark);
    @(negedge clk_i); start_i = 1'b1; mode_i = m; len_i = 16'(len);
    @(negedge clk_i); start_i = 1'b0;
    half(10);
    if (m) send_bits(good_mark ? 8'h74 : 8'h75, 7);
    else   send_bits(good_mark ? 8'h3A : 8'h3B, 6);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk_i);
  endtask

  int v0, k0, e0;
  task automatic snap();
    v0 = n_vld; k0 = n_ok; e0 = n_err;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(byte_vld_o === 0 && chk_o === 0 && busy_o === 0 && done_ok_o === 0 &&
          done_err_o === 0, "R1 reset outputs", int'(busy_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R4: mode 0, three bytes, good checksum
    snap();
    begin_frame(0, 3, 1);
    send_bits(8'h12, 8); send_bits(8'hA5, 8); send_bits(8'hFF, 8);
    send_bits(8'h12 ^ 8'hA5 ^ 8'hFF, 8);
    settle();
    check(n_ok == k0 + 1, "R4 mode-0 frame ok", n_ok - k0, 1);
    check(n_vld == v0 + 4, "R7 byte count", n_vld - v0, 4);

    // R5: mode 1
    snap();
    begin_frame(1, 2, 1);
    send_bits(8'h00, 8); send_bits(8'h81, 8); send_bits(8'h81, 8);
    settle();
    check(n_ok == k0 + 1, "R5 mode-1 frame ok", n_ok - k0, 1);

    // R8: bad checksum
    snap();
    begin_frame(0, 1, 1);
    send_bits(8'h5C, 8); send_bits(8'h5D, 8);
    settle();
    check(n_err == e0 + 1 && n_ok == k0, "R8 bad checksum err", n_err - e0, 1);

    // R6: wrong marker
    snap();
    begin_frame(0, 1, 0);
    settle();
    check(n_err == e0 + 1 && n_vld == v0, "R6 wrong marker", n_err - e0, 1);
    // R13: edges while idle
    snap();
    send_bits(8'hF0, 8);
    settle();
    check(n_vld == v0 && n_ok == k0 && n_err == e0, "R13 idle edges silent", n_vld - v0, 0);

    // R12: zero length
    snap();
    begin_frame(1, 0, 1);
    send_bits(8'h00, 8);
    settle();
    check(n_vld == v0 + 1 && n_ok == k0 + 1, "R12 zero length", n_vld - v0, 1);

    // R3: threshold edge, 59 -> 0, 60 -> 1
    snap();
    begin_frame(0, 1, 1);
    for (int i = 7; i >= 0; i--) begin
      if (8'hA5 >> i & 1) bit_t(30, 30); else bit_t(29, 30);
    end
    send_bits(8'hA5, 8);
    settle();
    check(n_ok == k0 + 1, "R3 threshold bits", n_ok - k0, 1);

    // R11: start pulse mid-frame
    snap();
    begin_frame(1, 1, 1);
    @(negedge clk_i); start_i = 1'b1; mode_i = 1'b0; len_i = 16'd9;
    @(negedge clk_i); start_i = 1'b0;
    repeat (18) @(negedge clk_i);
    tape = ~tape;
    half(20);
    send_bits(8'h6C, 7);
    send_bits(8'h6C, 8);
    settle();
    check(n_ok == k0 + 1 && n_vld == v0 + 2, "R11 start ignored", n_ok - k0, 1);

    // R9: short interval
    snap();
    begin_frame(0, 2, 1);
    send_bit(1);
    half(4);
    settle();
    check(n_err == e0 + 1, "R9 short interval", n_err - e0, 1);

    // R10: timeout after marker
    snap();
    begin_frame(1, 2, 1);
    repeat (T_MAX + 20) @(negedge clk_i);
    check(n_err == e0 + 1, "R10 timeout", n_err - e0, 1);

    // R10/R2: timeout waiting for reference edge
    snap();
    @(negedge clk_i); start_i = 1'b1; mode_i = 1'b0; len_i = 16'd1;
    @(negedge clk_i); start_i = 1'b0;
    check(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
    repeat (T_MAX + 20) @(negedge clk_i);
    check(n_err == e0 + 1, "R10 no reference edge", n_err - e0, 1);

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      fin = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule